// File: doc/BRIEF.md
# Power-Down Entry and Exit Sequencer

This block turns an asynchronous power-down request pin into a clean internal "asleep" state for a signal-processing core. The pin is first brought into the clock domain through a two-stage synchronizer. A sequencer then counts clock cycles before it puts the core to sleep, and counts far more cycles before it wakes the core again. A range-select input picks which of two clock-frequency bands the part runs in, and the two waits are twice as long in the upper band.

Entry into power-down is held back while the control bus is busy, and it cannot start until the first reset has been released. While asleep, the block drops a core enable and a memory write enable, so register and memory contents are kept. It freezes the serial output word at its last value instead of muting it, and it forces the control-bus data pull-down off so the bus is never held low. An active-low synchronous reset returns the sequencer to the awake state and issues a single-cycle restart pulse to the processing program when reset is released.

Top module: `pwrdn_seq`

## Requirements
- R1: While `rst_n` is sampled low, `in_pd` is 0, `core_en` is 1, `sd_out` is all zeros and `prog_restart` is 0. `prog_restart` is 1 for exactly the one cycle that follows the first clock edge at which `rst_n` is sampled high.
- R2: `pd_req_pin` reaches the sequencer through two flops. With `clk_range_hi`=0, `in_pd` rises on the 1024th qualifying edge. A qualifying edge is one where the synchronized request is 1, `bus_busy` is 0 and reset has been released. For a request set just after an edge, with the bus idle throughout, this is 1026 edges later.
- R3: With `clk_range_hi`=1, entry takes 2048 qualifying edges, which is 2050 edges after the pin rises.
- R4: With `clk_range_hi`=0, `in_pd` falls on the 32768th edge at which the synchronized request is 0. That is 32770 edges after the pin falls.
- R5: With `clk_range_hi`=1, exit takes 65536 such edges, which is 65538 edges after the pin falls.
- R6: If the request is withdrawn before entry completes, the entry is cancelled and its count is cleared. A later request waits the full entry time again.
- R7: Edges with `bus_busy`=1 do not count toward entry. A request made while the bus is busy stays pending, and its count starts or resumes on the next idle edge. `in_pd` never rises right after an edge with `bus_busy`=1.
- R8: A request held during reset has no effect until reset is released, and its entry count starts only after release.
- R9: `sd_out` is `sd_in` registered by one edge while awake. On edges where `in_pd` is 1, `sd_out` keeps its previous value.
- R10: `core_en` = !`in_pd`. `sda_low_out` is `sda_low_in` while awake and 0 while asleep. `mem_we_out` is `mem_we_in` while awake and 0 while asleep.
- R11: Re-asserting the request while the exit count runs aborts the exit. `in_pd` stays 1 and the exit count is cleared, so a later release waits the full exit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_req_pin | input | 1 | Asynchronous power-down request, 1 requests sleep |
| clk_range_hi | input | 1 | 0 selects the lower clock band, 1 selects the upper band |
| bus_busy | input | 1 | Control-bus transfer in progress |
| sd_in | input | SD_W | Serial output word from the core |
| sda_low_in | input | 1 | Bus logic wants to pull the data line low |
| mem_we_in | input | 1 | Core memory write enable |
| sd_out | output | SD_W | Serial output word, frozen while asleep |
| sda_low_out | output | 1 | Gated data-line pull-down |
| mem_we_out | output | 1 | Gated memory write enable |
| core_en | output | 1 | Core activity enable |
| in_pd | output | 1 | Block is in power-down |
| prog_restart | output | 1 | One-cycle program restart pulse after reset |

## Verification
The sequencer is driven with a request held through reset, with clean requests in both clock bands, and with a request withdrawn part-way through entry. A release is aborted part-way through exit to show that the counters clear rather than pause. One request is made under a bus-busy window that splits the count into two pieces. The exact rise and fall edge in each case separates the two bands from each other, clearing from pausing, and busy gating from a plain delay. The serial word and the bus pull-down change on every cycle, which shows the difference between freezing and muting the outputs.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    typedef enum logic [1:0] {
        PD_AWAKE  = 2'd0,
        PD_ARMING = 2'd1,
        PD_ASLEEP = 2'd2,
        PD_WAKING = 2'd3
    } pd_state_e;

    function automatic int unsigned span(input int unsigned mult, input int unsigned base);
        return mult * base;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned maxv);
        return $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrdn_rstmon.sv
module pwrdn_rstmon (
    input  logic clk,
    input  logic rst,
    output logic ready,
    output logic restart
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready   <= 1'b0;
            restart <= 1'b0;
        end else begin
            ready   <= 1'b1;
            restart <= ~ready;
        end
    end

    // R1: the restart pulse lasts one cycle
    p_restart_single_r1: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
    import pwrdn_pkg::*;
#(
    parameter int unsigned BASE_LO    = 256,
    parameter int unsigned BASE_HI    = 512,
    parameter int unsigned ENTRY_MULT = 4,
    parameter int unsigned EXIT_MULT  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic range_hi,
    input  logic busy,
    input  logic ready,
    output logic asleep
);
    localparam int unsigned ENT_LO = span(ENTRY_MULT, BASE_LO);
    localparam int unsigned ENT_HI = span(ENTRY_MULT, BASE_HI);
    localparam int unsigned EXT_LO = span(EXIT_MULT, BASE_LO);
    localparam int unsigned EXT_HI = span(EXIT_MULT, BASE_HI);
    localparam int unsigned MAXV   = max2(max2(ENT_LO, ENT_HI), max2(EXT_LO, EXT_HI));
    localparam int unsigned CW     = cnt_width(MAXV);

    pd_state_e       state;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   ent_lim;
    logic [CW-1:0]   ext_lim;
    logic            ent_last;
    logic            ext_last;

    assign ent_lim  = range_hi ? CW'(ENT_HI) : CW'(ENT_LO);
    assign ext_lim  = range_hi ? CW'(EXT_HI) : CW'(EXT_LO);
    assign ent_last = (cnt >= ent_lim - 1'b1);
    assign ext_last = (cnt >= ext_lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PD_AWAKE;
            cnt   <= '0;
        end else begin
            unique case (state)
                PD_AWAKE: begin
                    if (req && ready && !busy) begin
                        state <= PD_ARMING;
                        cnt   <= CW'(1);
                    end
                end
                PD_ARMING: begin
                    if (!req) begin
                        state <= PD_AWAKE;
                        cnt   <= '0;
                    end else if (!busy) begin
                        if (ent_last) begin
                            state <= PD_ASLEEP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PD_ASLEEP: begin
                    if (!req) begin
                        state <= PD_WAKING;
                        cnt   <= CW'(1);
                    end
                end
                PD_WAKING: begin
                    if (req) begin
                        state <= PD_ASLEEP;
                        cnt   <= '0;
                    end else if (ext_last) begin
                        state <= PD_AWAKE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= PD_AWAKE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign asleep = (state == PD_ASLEEP) || (state == PD_WAKING);

    // R7: entry never completes right after a busy edge
    p_entry_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> !$past(busy));

    // R7: a busy edge freezes the entry count
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PD_ARMING && req && busy) |=> (state == PD_ARMING && $stable(cnt)));

    // R8: entry needs a released reset
    p_entry_ready_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(ready));

    // R6: a withdrawn request cancels and clears the entry count
    p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (state == PD_ARMING && !req) |=> (state == PD_AWAKE && cnt == '0));

    // R11: a renewed request aborts the exit
    p_wake_abort_r11: assert property (@(posedge clk) disable iff (rst)
        (state == PD_WAKING && req) |=> (state == PD_ASLEEP && cnt == '0));
endmodule

// File: rtl/pwrdn_gate.sv
module pwrdn_gate #(
    parameter int unsigned SD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            asleep,
    input  logic [SD_W-1:0] sd_in,
    input  logic            sda_low_in,
    input  logic            mem_we_in,
    output logic [SD_W-1:0] sd_out,
    output logic            sda_low_out,
    output logic            mem_we_out,
    output logic            core_en
);
    logic [SD_W-1:0] sd_q;

    always_ff @(posedge clk) begin
        if (rst)          sd_q <= '0;
        else if (!asleep) sd_q <= sd_in;
    end

    assign sd_out      = sd_q;
    assign core_en     = ~asleep;
    assign sda_low_out = sda_low_in & ~asleep;
    assign mem_we_out  = mem_we_in & ~asleep;

    // R9: the serial word is frozen after an asleep edge
    p_sd_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        $past(asleep) |-> $stable(sd_out));

    // R10: the data line is never pulled low while asleep
    p_sda_release_r10: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (!sda_low_out && !mem_we_out));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
    parameter int unsigned SD_W       = 16,
    parameter int unsigned SYNC_STAGE = 2,
    parameter int unsigned BASE_LO    = 256,
    parameter int unsigned BASE_HI    = 512,
    parameter int unsigned ENTRY_MULT = 4,
    parameter int unsigned EXIT_MULT  = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_req_pin,
    input  logic            clk_range_hi,
    input  logic            bus_busy,
    input  logic [SD_W-1:0] sd_in,
    input  logic            sda_low_in,
    input  logic            mem_we_in,
    output logic [SD_W-1:0] sd_out,
    output logic            sda_low_out,
    output logic            mem_we_out,
    output logic            core_en,
    output logic            in_pd,
    output logic            prog_restart
);
    logic rst;
    logic req_s;
    logic ready;
    logic asleep;

    assign rst = ~rst_n;

    pwrdn_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pd_req_pin),
        .q       (req_s)
    );

    pwrdn_rstmon u_rstmon (
        .clk     (clk),
        .rst     (rst),
        .ready   (ready),
        .restart (prog_restart)
    );

    pwrdn_fsm #(
        .BASE_LO    (BASE_LO),
        .BASE_HI    (BASE_HI),
        .ENTRY_MULT (ENTRY_MULT),
        .EXIT_MULT  (EXIT_MULT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req_s),
        .range_hi (clk_range_hi),
        .busy     (bus_busy),
        .ready    (ready),
        .asleep   (asleep)
    );

    pwrdn_gate #(.SD_W(SD_W)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .asleep      (asleep),
        .sd_in       (sd_in),
        .sda_low_in  (sda_low_in),
        .mem_we_in   (mem_we_in),
        .sd_out      (sd_out),
        .sda_low_out (sda_low_out),
        .mem_we_out  (mem_we_out),
        .core_en     (core_en)
    );

    assign in_pd = asleep;
endmodule

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
    localparam int SD_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd_req_pin = 1'b0;
    logic            clk_range_hi = 1'b0;
    logic            bus_busy = 1'b0;
    logic [SD_W-1:0] sd_in = '0;
    logic            sda_low_in = 1'b0;
    logic            mem_we_in = 1'b0;
    logic [SD_W-1:0] sd_out;
    logic            sda_low_out, mem_we_out, core_en, in_pd, prog_restart;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit              m_s1, m_s2, m_pd, m_seen, m_rs;
    int              m_cnt;
    logic [SD_W-1:0] m_sd;

    always #2 clk = ~clk;

    pwrdn_seq #(.SD_W(SD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pd_req_pin(pd_req_pin),
        .clk_range_hi(clk_range_hi), .bus_busy(bus_busy),
        .sd_in(sd_in), .sda_low_in(sda_low_in), .mem_we_in(mem_we_in),
        .sd_out(sd_out), .sda_low_out(sda_low_out), .mem_we_out(mem_we_out),
        .core_en(core_en), .in_pd(in_pd), .prog_restart(prog_restart)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the requirements, stepped on each edge
    always @(posedge clk) begin
        int  e_lim, x_lim;
        bit  old_pd;
        e_lim  = clk_range_hi ? 2048 : 1024;
        x_lim  = clk_range_hi ? 65536 : 32768;
        old_pd = m_pd;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pd = 0; m_cnt = 0;
            m_seen = 0; m_rs = 0; m_sd = '0;
        end else begin
            if (!m_pd) begin
                if (m_s2 && !bus_busy && m_seen) begin
                    if (m_cnt + 1 >= e_lim) begin m_pd = 1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end else if (!m_s2) m_cnt = 0;
            end else begin
                if (!m_s2) begin
                    if (m_cnt + 1 >= x_lim) begin m_pd = 0; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end else m_cnt = 0;
            end
            if (!old_pd) m_sd = sd_in;
            m_rs   = !m_seen;
            m_seen = 1;
            m_s2   = m_s1;
            m_s1   = pd_req_pin;
        end
    end

    // free-running data-side stimulus
    always @(negedge clk) begin
        cyc        <= cyc + 1;
        sd_in      <= SD_W'(cyc * 37 + (cyc >> 3));
        sda_low_in <= cyc[0];
        mem_we_in  <= cyc[1];
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            chk(cur_req, int'(in_pd), int'(m_pd));
            chk("R10 core_en", int'(core_en), int'(!m_pd));
            chk("R9 sd_out", int'(sd_out), int'(m_sd));
            chk("R10 sda_low_out", int'(sda_low_out), int'(sda_low_in & !m_pd));
            chk("R10 mem_we_out", int'(mem_we_out), int'(mem_we_in & !m_pd));
            chk("R1 prog_restart", int'(prog_restart), int'(m_rs));
        end
    end

    task automatic measure(input logic target, output int n);
        n = 0;
        while (in_pd !== target && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        logic [SD_W-1:0] snap;
        // R8: request already high while reset is held
        pd_req_pin = 1'b1;
        idle(3);
        cmp_en = 1'b1;
        idle(2000);
        cur_req = "R1";
        chk("R1 in_pd in reset", int'(in_pd), 0);
        chk("R1 core_en in reset", int'(core_en), 1);
        chk("R1 sd_out in reset", int'(sd_out), 0);
        chk("R8 no entry during reset", int'(in_pd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 restart pulse high", int'(prog_restart), 1);
        @(negedge clk);
        chk("R1 restart pulse low", int'(prog_restart), 0);
        cur_req = "R8";
        measure(1'b1, n);
        chk("R8 R2 entry latency after release", n + 2, 1026);

        // R9 freeze while asleep
        snap = sd_out;
        idle(20);
        chk("R9 sd_out frozen", int'(sd_out), int'(snap));
        chk("R10 sda released asleep", int'(sda_low_out), 0);

        // R4 low-band exit
        cur_req = "R4";
        pd_req_pin = 1'b0;
        measure(1'b0, n);
        chk("R4 exit latency low band", n, 32770);

        // R3 high-band entry
        cur_req = "R3";
        clk_range_hi = 1'b1;
        idle(5);
        pd_req_pin = 1'b1;
        measure(1'b1, n);
        chk("R3 entry latency high band", n, 2050);

        // R11 aborted exit, then R5 full exit
        cur_req = "R11";
        pd_req_pin = 1'b0;
        idle(1000);
        chk("R11 still asleep mid exit", int'(in_pd), 1);
        pd_req_pin = 1'b1;
        idle(10);
        chk("R11 exit aborted", int'(in_pd), 1);
        cur_req = "R5";
        pd_req_pin = 1'b0;
        measure(1'b0, n);
        chk("R5 R11 full exit latency high band", n, 65538);

        // R6 cancelled entry
        cur_req = "R6";
        clk_range_hi = 1'b0;
        idle(5);
        pd_req_pin = 1'b1;
        idle(500);
        chk("R6 not asleep mid entry", int'(in_pd), 0);
        pd_req_pin = 1'b0;
        idle(10);
        pd_req_pin = 1'b1;
        measure(1'b1, n);
        chk("R6 R2 full entry after cancel", n, 1026);
        pd_req_pin = 1'b0;
        measure(1'b0, n);
        chk("R4 second exit", n, 32770);

        // R7 bus busy windows
        cur_req = "R7";
        idle(5);
        bus_busy = 1'b1;
        pd_req_pin = 1'b1;
        n = 0;
        while (in_pd !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
            if (n == 300) bus_busy = 1'b0;
            if (n == 400) bus_busy = 1'b1;
            if (n == 450) bus_busy = 1'b0;
        end
        chk("R7 entry latency with busy windows", n, 1374);

        // R1 reset while asleep
        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset wakes", int'(in_pd), 0);
        chk("R1 core_en after reset", int'(core_en), 1);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 restart after second reset", int'(prog_restart), 1);
        @(negedge clk);
        chk("R1 restart ends", int'(prog_restart), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule